// File: doc/BRIEF.md
# Converter Power-Up and Mute Sequencer

This controller brings an audio converter out of reset in an orderly way and keeps its outputs silenced whenever the analog path is not ready. After the active-low reset is released it waits a number of frame-clock (LRCK) periods that depends on the selected speed mode. It then enables the quiescent reference and times a fixed power-up interval in system clocks. Only after that does it report power-up complete and hand the per-channel mute controls over to the mute requests.

The frame clock arrives asynchronously. It is passed through a two-stage synchronizer, and only its rising edges are used. A watchdog counter declares the frame clock lost when no rising edge arrives within a set number of system clocks. On loss the sequencer drops the reference enable, mutes both channels and waits for the clock to return. It then repeats the whole wait and power-up sequence.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `vq_en` and `pwr_done` are 0 and `mute_ctl` is 2'b11. This holds immediately, without waiting for a clock edge.
- R2: `lrck_in` passes through two synchronizing flip-flops, and only its rising edges advance the wait count. The state change caused by a rising edge appears on the third `clk` rising edge after `lrck_in` goes high.
- R3: The wait after reset is counted in LRCK rising edges, and `vq_en` stays 0 until the last of them. The length is BASE_WAIT for `speed` 2'b00, 2×BASE_WAIT for 2'b01, and 4×BASE_WAIT for 2'b10 and for 2'b11.
- R4: When the wait completes, `vq_en` goes to 1 and stays 1 for PWRUP_CYCLES system clocks with `pwr_done` at 0. After that interval the sequencer enters the running state.
- R5: `pwr_done` is 1 only in the running state, and it goes to 1 exactly PWRUP_CYCLES clocks after `vq_en` rises.
- R6: Outside the running state, `mute_ctl` is 2'b11 whatever `mute_req` is. This covers reset, the wait, the power-up phase and clock loss.
- R7: In the running state, `mute_ctl[i]` equals `mute_req[i]` for each channel independently. Bit 0 is channel A and bit 1 is channel B, and both are active high.
- R8: If no LRCK rising edge arrives for LOSS_CYCLES system clocks, the sequencer enters the lost state. In that state `vq_en` and `pwr_done` are 0 and both mutes are active.
- R9: In the lost state, the first returning LRCK rising edge counts as edge one of a complete new wait. A full power-up interval then follows that wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Frame clock, asynchronous to `clk` |
| speed | input | 2 | Speed mode: 00 single, 01 double, 10/11 quad |
| mute_req | input | 2 | Per-channel mute requests, bit 0 = A |
| vq_en | output | 1 | Quiescent reference enable |
| pwr_done | output | 1 | Power-up complete, running state |
| mute_ctl | output | 2 | Per-channel external mute control, active high |

## Verification
The bench builds the block with BASE_WAIT=4, PWRUP_CYCLES=10 and LOSS_CYCLES=40. With these values, every speed code, including the aliased quad code, completes its wait in at most 16 frame periods. The edge of each wait count and of the power-up interval can then be sampled cycle by cycle. It also becomes cheap to sweep all four mute-request patterns, to starve the frame clock past the loss threshold and to watch a full recovery.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_WAIT    = 3'd1,
    ST_POWERUP = 3'd2,
    ST_RUN     = 3'd3,
    ST_LOST    = 3'd4
  } seq_state_t;

  // Number of frame-clock rising edges to wait for a given speed code.
  function automatic int unsigned wait_periods(input int unsigned base,
                                               input logic [1:0] mode);
    case (mode)
      2'b00:   wait_periods = base;
      2'b01:   wait_periods = base * 2;
      default: wait_periods = base * 4;
    endcase
  endfunction

endpackage

// File: rtl/lrck_sync_edge.sv
module lrck_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck_in,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= lrck_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/lrck_loss_mon.sv
module lrck_loss_mon #(
  parameter int unsigned LOSS_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic loss_o
);
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_q <= '0;
    else if (rise_i)         idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign loss_o = (idle_q == LIMIT) && !rise_i;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import dps_pkg::*;
#(
  parameter int unsigned BASE_WAIT    = 512,
  parameter int unsigned PWRUP_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       loss_i,
  input  logic [1:0] speed_i,
  output seq_state_t state_o
);
  localparam int unsigned EW = $clog2(4 * BASE_WAIT + 1);
  localparam int unsigned PW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [PW-1:0] PW_LAST = PW'(PWRUP_CYCLES - 1);

  seq_state_t    state_q;
  logic [EW-1:0] edge_q;
  logic [PW-1:0] pw_q;
  logic [EW-1:0] target;

  assign target = EW'(wait_periods(BASE_WAIT, speed_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      edge_q  <= '0;
      pw_q    <= '0;
    end else begin
      case (state_q)
        ST_RESET: begin
          state_q <= ST_WAIT;
          edge_q  <= '0;
        end
        ST_WAIT: begin
          if (loss_i) begin
            state_q <= ST_LOST;
          end else if (rise_i) begin
            if (edge_q + 1'b1 >= target) begin
              state_q <= ST_POWERUP;
              pw_q    <= '0;
            end else begin
              edge_q <= edge_q + 1'b1;
            end
          end
        end
        ST_POWERUP: begin
          if (loss_i)              state_q <= ST_LOST;
          else if (pw_q == PW_LAST) state_q <= ST_RUN;
          else                     pw_q <= pw_q + 1'b1;
        end
        ST_RUN: begin
          if (loss_i) state_q <= ST_LOST;
        end
        ST_LOST: begin
          if (rise_i) begin
            state_q <= ST_WAIT;
            edge_q  <= EW'(1);
          end
        end
        default: state_q <= ST_RESET;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dps_pkg::*;
#(
  parameter int unsigned BASE_WAIT    = 512,
  parameter int unsigned PWRUP_CYCLES = 2500,
  parameter int unsigned LOSS_CYCLES  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_in,
  input  logic [1:0] speed,
  input  logic [1:0] mute_req,
  output logic       vq_en,
  output logic       pwr_done,
  output logic [1:0] mute_ctl
);
  logic       rise_evt;
  logic       loss_evt;
  seq_state_t state;

  lrck_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .rise_o(rise_evt)
  );

  lrck_loss_mon #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_evt), .loss_o(loss_evt)
  );

  pwr_seq_fsm #(.BASE_WAIT(BASE_WAIT), .PWRUP_CYCLES(PWRUP_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_evt), .loss_i(loss_evt),
    .speed_i(speed), .state_o(state)
  );

  assign vq_en    = rst_n && (state == ST_POWERUP || state == ST_RUN);
  assign pwr_done = rst_n && (state == ST_RUN);
  assign mute_ctl = pwr_done ? mute_req : 2'b11;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int unsigned PWRUP_CYCLES = 2500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rise_evt,
  input logic       loss_evt,
  input logic       vq_en,
  input logic       pwr_done,
  input logic [1:0] mute_ctl,
  input logic [1:0] mute_req
);
  int unsigned pw_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pw_seen <= 0;
    else if (!vq_en)           pw_seen <= 0;
    else if (!pwr_done)        pw_seen <= pw_seen + 1;
  end

  assert_muted_unless_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vq_en |-> (mute_ctl == 2'b11));

  assert_run_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_done |-> (mute_ctl == mute_req));

  assert_vq_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vq_en) |-> $past(rise_evt));

  assert_pwrup_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_done) |-> (pw_seen == PWRUP_CYCLES));

  assert_loss_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> !vq_en && !pwr_done);

  assert_done_needs_vq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_done |-> vq_en);
endmodule

bind dac_pwr_seq dps_checker #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .loss_evt(loss_evt),
  .vq_en(vq_en), .pwr_done(pwr_done), .mute_ctl(mute_ctl), .mute_req(mute_req)
);

// File: tb/tb_dac_pwr_seq.sv
`timescale 1ns/1ps
module tb_dac_pwr_seq;
  localparam int BASE = 4;
  localparam int PWR  = 10;
  localparam int LOSS = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic lrck = 0;
  logic [1:0] speed = 0;
  logic [1:0] mute_req = 0;
  logic vq_en, pwr_done;
  logic [1:0] mute_ctl;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_pwr_seq #(.BASE_WAIT(BASE), .PWRUP_CYCLES(PWR), .LOSS_CYCLES(LOSS)) dut (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck), .speed(speed),
    .mute_req(mute_req), .vq_en(vq_en), .pwr_done(pwr_done), .mute_ctl(mute_ctl)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Outputs packed as {vq_en, pwr_done, mute_ctl}
  function automatic logic [3:0] outs();
    return {vq_en, pwr_done, mute_ctl};
  endfunction

  function automatic int exp_wait(input int sp);
    int sh;
    sh = (sp > 2) ? 2 : sp;
    return BASE << sh;
  endfunction

  task automatic lrck_cycle();
    lrck = 1;
    repeat (4) @(negedge clk);
    lrck = 0;
    repeat (4) @(negedge clk);
  endtask

  // Drives n rising edges and checks wait, power-up and run timing.
  task automatic pwrup_seq(input int n, input string tag);
    repeat (n - 1) lrck_cycle();
    check({"R3 still waiting ", tag}, outs(), 4'b0011);
    lrck = 1;
    @(negedge clk);
    @(negedge clk);
    check({"R2 sync latency ", tag}, outs(), 4'b0011);
    @(negedge clk);
    check({"R4 vq on last edge ", tag}, outs(), 4'b1011);
    repeat (PWR - 1) @(negedge clk);
    check({"R4 powerup held ", tag}, outs(), 4'b1011);
    @(negedge clk);
    check({"R5 run reached ", tag}, outs(), 4'b1100);
    lrck = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mute_req = 2'b01;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 4'b0011);
    mute_req = 2'b00;

    for (int sp = 0; sp < 4; sp++) begin
      rst_n = 0;
      speed = 2'(sp);
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      pwrup_seq(exp_wait(sp), $sformatf("speed %0d", sp));
      for (int m = 0; m < 4; m++) begin
        mute_req = 2'(m);
        lrck_cycle();
        check($sformatf("R7 mute pattern %0d", m), outs(), {2'b11, 2'(m)});
      end
      mute_req = 2'b00;
    end

    // Frame clock stalls: still running before the limit, lost after it.
    mute_req = 2'b10;
    lrck_cycle();
    repeat (30) @(negedge clk);
    check("R8 before limit", outs(), 4'b1110);
    repeat (30) @(negedge clk);
    check("R8 lost state", outs(), 4'b0011);
    mute_req = 2'b00;
    check("R6 lost ignores req", outs(), 4'b0011);

    // Recovery: the first returning edge counts as edge one.
    pwrup_seq(exp_wait(3), "R9 recovery");

    // Asynchronous reset from the running state.
    #3 rst_n = 0;
    #1 check("R1 async reset", outs(), 4'b0011);
    @(negedge clk);
    rst_n = 1;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule